// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Window Test

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It drives the code of an external digital-to-analog converter (DAC), controls the track/hold strobe, and reads a single comparator bit once per decision. It has two jobs. A full conversion first tracks the input with the DAC parked at mid-scale. It then resolves the code one bit at a time, starting at the most significant bit. A window test skips the search. It places two limit codes on the DAC in turn and reports whether the comparator gave the expected answer at each.

Every decision step shows its DAC code for a programmable number of settle cycles before the comparator is read. The track phase length is programmable as well. Each time the converter is switched on, it runs one conversion whose result is thrown away. This lets the analog front end reach a known state before any result is reported.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, `dac` is 0x200, `hold` is 1, and `result`, `done` and `pass` are 0.
- R2: An accepted start with `mode`=0 drives `hold` low for exactly `sample_cycles`+1 cycles. `dac` stays at 0x200 for all of those cycles.
- R3: After tracking, `hold` stays high for 10 decision steps. Each step lasts `settle_cycles`+1 cycles and samples `cmp` in its last cycle. The first trial code is 0x200. Each later trial sets the next lower bit. A trial bit is kept when `cmp` is 1 and cleared when it is 0.
- R4: `done` is high for exactly one cycle. For a conversion, it rises `sample_cycles`+1+10×(`settle_cycles`+1) cycles after the clock edge that accepts `start`. `result` changes only in a cycle where `done` is high.
- R5: When `en` rises, the block runs one full conversion on its own. It raises no `done`, leaves `result` unchanged, and ignores `start` while that conversion runs.
- R6: With `mode`=1, `dac` shows `lim_lo` for `settle_cycles`+1 cycles and then `lim_hi` for the same length. It drives no other code, and `hold` stays high throughout.
- R7: In the window test, `pass` is 1 only if `cmp` was 0 with `lim_lo` applied and 1 with `lim_hi` applied. A wrong answer at `lim_lo` ends the test at once: `done` comes `settle_cycles`+1 cycles after acceptance, with `pass` 0.
- R8: A `start` during a conversion or window test has no effect. The running job ends at its normal time with its own answer, and no extra `done` follows.
- R9: Dropping `en` aborts any job. No `done` is given, `result` keeps its value, `hold` returns high and `dac` returns to 0x200. Raising `en` again repeats the discarded conversion.
- R10: `mode`, `lim_lo` and `lim_hi` are captured when `start` is accepted. An accepted start clears `pass`, and only a window test can set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable |
| start | input | 1 | Request a job while idle |
| mode | input | 1 | 0 = conversion, 1 = window test |
| lim_lo | input | W | Lower window code |
| lim_hi | input | W | Upper window code |
| sample_cycles | input | TIME_W | Track length minus one |
| settle_cycles | input | TIME_W | Settle wait per decision |
| cmp | input | 1 | Comparator bit |
| dac | output | W | DAC code |
| hold | output | 1 | 0 = track, 1 = hold |
| result | output | W | Last conversion code |
| done | output | 1 | One-cycle job-complete pulse |
| pass | output | 1 | Window test verdict |

## Verification
The bench builds the block with a 10-bit code and a 4-bit timing field. It uses a track time of four cycles and runs the settle wait both at zero and at three cycles. The short windows keep each conversion at a few dozen cycles, so the exact `done` cycle can be counted. The zero-settle case tests whether the counter reload is placed right on back-to-back decisions. A comparator modelled in the bench from an integer input level reaches the code extremes 0 and 1023, the exact window boundary, and both failure exits of the window test.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_TRACK,
        ST_DECIDE,
        ST_WIN_LO,
        ST_WIN_HI
    } sar_state_e;
endpackage

// File: rtl/sar_timer.sv
module sar_timer #(
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic              expired
);
    logic [TIME_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R3: the wait only ever counts down when not reloaded
    assert_timer_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sar_bitsel.sv
module sar_bitsel #(
    parameter int W  = 10,
    parameter int IW = $clog2(W)
) (
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  mask
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask[i] = (idx == IW'(i));
    end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int W      = 10,
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic              mode,
    input  logic [W-1:0]      lim_lo,
    input  logic [W-1:0]      lim_hi,
    input  logic [TIME_W-1:0] sample_cycles,
    input  logic [TIME_W-1:0] settle_cycles,
    input  logic              cmp,
    output logic [W-1:0]      dac,
    output logic              hold,
    output logic [W-1:0]      result,
    output logic              done,
    output logic              pass
);
    import sar_pkg::*;

    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    typedef struct packed {
        sar_state_e    state;
        logic [W-1:0]  code;
        logic [IW-1:0] idx;
        logic          discard;
        logic [W-1:0]  lo;
        logic [W-1:0]  hi;
        logic [W-1:0]  result;
        logic          done;
        logic          pass;
        logic          hold;
    } sar_regs_t;

    sar_regs_t r_d, r_q;

    logic              tmr_load;
    logic [TIME_W-1:0] tmr_val;
    logic              tmr_exp;
    logic [W-1:0]      trial_mask;

    sar_timer #(.TIME_W(TIME_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sar_bitsel #(.W(W), .IW(IW)) u_bitsel (
        .idx  (r_q.idx),
        .mask (trial_mask)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = settle_cycles;
        if (!en) begin
            r_d.state = ST_OFF;
            r_d.hold  = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_OFF: begin
                    r_d.state   = ST_TRACK;
                    r_d.discard = 1'b1;
                    r_d.code    = '0;
                    r_d.hold    = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = sample_cycles;
                end
                ST_IDLE: begin
                    if (start) begin
                        r_d.pass    = 1'b0;
                        r_d.lo      = lim_lo;
                        r_d.hi      = lim_hi;
                        r_d.discard = 1'b0;
                        tmr_load    = 1'b1;
                        if (mode) begin
                            r_d.state = ST_WIN_LO;
                        end else begin
                            r_d.state = ST_TRACK;
                            r_d.code  = '0;
                            r_d.hold  = 1'b0;
                            tmr_val   = sample_cycles;
                        end
                    end
                end
                ST_TRACK: begin
                    if (tmr_exp) begin
                        r_d.state = ST_DECIDE;
                        r_d.hold  = 1'b1;
                        r_d.idx   = IW'(W - 1);
                        tmr_load  = 1'b1;
                    end
                end
                ST_DECIDE: begin
                    if (tmr_exp) begin
                        if (cmp) r_d.code = r_q.code | trial_mask;
                        if (r_q.idx == '0) begin
                            r_d.state = ST_IDLE;
                            if (!r_q.discard) begin
                                r_d.done   = 1'b1;
                                r_d.result = cmp ? (r_q.code | trial_mask) : r_q.code;
                            end
                        end else begin
                            r_d.idx  = r_q.idx - 1'b1;
                            tmr_load = 1'b1;
                        end
                    end
                end
                ST_WIN_LO: begin
                    if (tmr_exp) begin
                        if (cmp) begin
                            r_d.state = ST_IDLE;
                            r_d.done  = 1'b1;
                            r_d.pass  = 1'b0;
                        end else begin
                            r_d.state = ST_WIN_HI;
                            tmr_load  = 1'b1;
                        end
                    end
                end
                ST_WIN_HI: begin
                    if (tmr_exp) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.pass  = cmp;
                    end
                end
                default: r_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_OFF;
            r_q.code    <= '0;
            r_q.idx     <= '0;
            r_q.discard <= 1'b0;
            r_q.lo      <= '0;
            r_q.hi      <= '0;
            r_q.result  <= '0;
            r_q.done    <= 1'b0;
            r_q.pass    <= 1'b0;
            r_q.hold    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_DECIDE: dac = r_q.code | trial_mask;
            ST_WIN_LO: dac = r_q.lo;
            ST_WIN_HI: dac = r_q.hi;
            default:   dac = MID;
        endcase
    end

    assign hold   = r_q.hold;
    assign result = r_q.result;
    assign done   = r_q.done;
    assign pass   = r_q.pass;

    // R2: mid-scale code whenever tracking
    assert_mid_while_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> dac == MID);
    // R3: hold stays high across every decision step
    assert_hold_in_decide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DECIDE) |-> hold);
    // R4: done is a single-cycle pulse
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: result moves only together with done
    assert_result_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);
    // R5: the discarded conversion never reports
    assert_no_done_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DECIDE && r_q.discard) |=> !done);
    // R6: window test keeps hold high
    assert_win_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WIN_LO || r_q.state == ST_WIN_HI) |-> hold);
    // R7: a passing verdict appears only with done
    assert_pass_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass) |-> done);
    // R9: disable forces the block off
    assert_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (hold && !done));
endmodule

// File: tb/sar_ctrl_test.sv
module sar_ctrl_test;
    localparam int W      = 10;
    localparam int TIME_W = 4;
    localparam int SAMP   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              start = 1'b0;
    logic              mode = 1'b0;
    logic [W-1:0]      lim_lo = '0;
    logic [W-1:0]      lim_hi = '0;
    logic [TIME_W-1:0] sample_cycles = TIME_W'(SAMP);
    logic [TIME_W-1:0] settle_cycles = '0;
    logic              cmp;
    logic [W-1:0]      dac;
    logic              hold;
    logic [W-1:0]      result;
    logic              done;
    logic              pass;

    int vin = 0;
    bit inv = 1'b0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // comparator model: normal polarity for conversions, inverted for window tests
    assign cmp = inv ? (int'(dac) > vin) : (vin >= int'(dac));

    always #10 clk = ~clk;

    sar_ctrl #(.W(W), .TIME_W(TIME_W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start), .mode(mode),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .sample_cycles(sample_cycles),
        .settle_cycles(settle_cycles), .cmp(cmp), .dac(dac), .hold(hold),
        .result(result), .done(done), .pass(pass)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n, output int dones);
        dones = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
    endtask

    task automatic t_reset;
        chk("R1 dac", int'(dac), 512);
        chk("R1 hold", int'(hold), 1);
        chk("R1 result", int'(result), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 pass", int'(pass), 0);
    endtask

    task automatic t_discard;
        int dn;
        int r0;
        r0 = int'(result);
        @(negedge clk);
        en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done) dn++;
            start = (i == 6);
            mode  = 1'b0;
        end
        start = 1'b0;
        chk("R5 no done during discarded run", dn, 0);
        chk("R5 result kept", int'(result), r0);
        chk("R5 idle hold", int'(hold), 1);
    endtask

    task automatic t_convert(input int v, input int st, input bit poke_busy);
        int cyc;
        int lowc;
        int badmid;
        int tr1;
        int tr2;
        int hc;
        int extra;
        vin = v; inv = 1'b0; settle_cycles = TIME_W'(st);
        mode = 1'b0; start = 1'b1;
        cyc = 0; lowc = 0; badmid = 0; hc = 0; tr1 = -1; tr2 = -1;
        while (cyc < 400) begin
            @(negedge clk);
            cyc++;
            start = (poke_busy && cyc == 8);
            mode  = (poke_busy && cyc == 8);
            if (done) break;
            if (!hold) begin
                lowc++;
                if (dac != 10'h200) badmid++;
            end else if (cyc > 1) begin
                if (hc == 0) tr1 = int'(dac);
                if (hc == st + 1) tr2 = int'(dac);
                hc++;
            end
        end
        start = 1'b0; mode = 1'b0;
        chk("R4 done cycle", cyc, SAMP + 2 + W * (st + 1));
        chk("R2 hold low length", lowc, SAMP + 1);
        chk("R2 mid code while tracking", badmid, 0);
        chk("R3 first trial", tr1, 512);
        chk("R3 second trial", tr2, (v >= 512) ? 768 : 256);
        chk("R3 result", int'(result), v);
        chk("R10 pass after conversion", int'(pass), 0);
        @(negedge clk);
        chk("R4 done one cycle", int'(done), 0);
        idle_cycles(30, extra);
        chk("R8 no extra done", extra, 0);
        chk("R8 result unchanged", int'(result), v);
    endtask

    task automatic t_window(input int v, input int lo, input int hi, input int st,
                            input bit exp_pass, input bit early);
        int cyc;
        int loc;
        int hic;
        int other;
        int holdlow;
        int r0;
        int extra;
        r0 = int'(result);
        vin = v; inv = 1'b1; settle_cycles = TIME_W'(st);
        lim_lo = W'(lo); lim_hi = W'(hi); mode = 1'b1; start = 1'b1;
        cyc = 0; loc = 0; hic = 0; other = 0; holdlow = 0;
        while (cyc < 200) begin
            @(negedge clk);
            cyc++;
            start  = (cyc == 2);
            lim_lo = '0; lim_hi = '0; mode = 1'b0;
            if (done) break;
            if (!hold) holdlow++;
            if (int'(dac) == lo) loc++;
            else if (int'(dac) == hi) hic++;
            else other++;
        end
        start = 1'b0;
        chk("R7 done cycle", cyc, early ? st + 2 : 2 * (st + 1) + 1);
        chk("R6 low code cycles", loc, st + 1);
        chk("R6 high code cycles", hic, early ? 0 : st + 1);
        chk("R6 no other code", other, 0);
        chk("R6 hold stays high", holdlow, 0);
        chk("R7 verdict", int'(pass), int'(exp_pass));
        chk("R10 result untouched by window", int'(result), r0);
        idle_cycles(20, extra);
        chk("R8 no extra done", extra, 0);
        inv = 1'b0;
    endtask

    task automatic t_abort;
        int r0;
        int dn;
        r0 = int'(result);
        vin = 77; inv = 1'b0; settle_cycles = TIME_W'(1);
        mode = 1'b0; start = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) dn++;
        end
        en = 1'b0;
        idle_cycles(30, dn);
        chk("R9 no done after abort", dn, 0);
        chk("R9 result kept", int'(result), r0);
        chk("R9 hold high", int'(hold), 1);
        chk("R9 dac mid", int'(dac), 512);
        en = 1'b1;
        idle_cycles(60, dn);
        chk("R9 re-enable discards again", dn, 0);
        chk("R9 result still kept", int'(result), r0);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_discard();
        t_convert(341, 2, 1'b0);
        t_convert(0, 0, 1'b0);
        t_convert(1023, 3, 1'b1);
        t_convert(512, 0, 1'b1);
        t_window(500, 400, 600, 2, 1'b1, 1'b0);
        t_window(300, 400, 600, 2, 1'b0, 1'b1);
        t_window(700, 400, 600, 0, 1'b0, 1'b0);
        t_window(400, 400, 600, 0, 1'b1, 1'b0);
        t_abort();
        t_convert(600, 1, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule